// File: doc/BRIEF.md
# Prescaled Multi-Source Interval Timer

This block is a single down-counting interval timer controlled through a small register bus. Software writes an interval value, then writes the control register. The control register holds an enable bit, a self-clearing reload bit, a two-bit field that picks one of four tick-enable inputs, and a three-bit field that divides the chosen tick by a power of two from 1 to 128. While the timer is enabled, the counter steps down once per divided tick. When a period ends, the counter takes the interval value again and the block raises a single-cycle interrupt pulse. The counter keeps running after each period.

All four tick inputs are one-cycle enable strobes in the block's own clock domain. A build-time mask says which of these sources exist in a given integration. If the control register selects a source that does not exist, the counter freezes and a sticky error output is set. The divider's phase counter restarts on every control write, so a new source or divide ratio always starts from a clean phase. There is no data stream at the edge of this block. The bus, the tick strobes, the interrupt and the error flag are all plain control pins, and the bus is never back-pressured.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset the control, interval and count registers all read 0, irq is low, and src_err is low as long as source 0 is available.
- R2: The bus decodes bus_addr[3:0] only. Offset 0x0 is control, 0x4 is interval (its low CNT_W bits), and 0x8 is the count, which is read-only. A write to 0x8 has no effect, and a read of any other offset returns 0.
- R3: The control fields are: bit 0 enable, bits [3:2] source index, bits [6:4] prescale exponent, and bit 1 reload. Bit 1 always reads back as 0.
- R4: A control write with bit 1 set loads the counter with the interval register value at that same clock edge, whether or not the timer is enabled.
- R5: While enabled, the counter decrements once for every 2^exponent ticks of the selected source. While disabled, the counter holds its value.
- R6: A decrement that starts from 1 or from 0 loads the interval instead and makes irq high for exactly the next cycle. The interrupt period is therefore interval × 2^exponent source ticks, measured from a reloading control write.
- R7: Every control write restarts the divider phase. Ticks that arrive before the write do not shorten the first period after it.
- R8: If the selected source is not present in SRC_AVAIL, the counter does not change and src_err goes high one cycle later. src_err then stays high until reset, even after a valid source is selected.
- R9: Writing the interval register does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Tick-enable strobes of the four sources |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | 1 | One-cycle interrupt pulse at the end of each period |
| src_err | output | 1 | Sticky flag: an unavailable source was selected |

## Verification
The bench builds the block with CNT_W = 16 and SRC_AVAIL = 4'b1011, so source 2 is missing. That setting makes the frozen-counter and sticky-error path reachable from ordinary control writes. The three present sources tick every cycle, every second cycle and every third cycle. With these rates, the interrupt spacing of each configuration is an exact multiple of the interval and the divide ratio, and the largest divide of 128 still fits in a short run. The bench also rewrites the control register in the middle of a period, which brings the divider-phase restart within reach of a measured gap.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int NSRC  = 4;
  localparam int EXP_W = 3;
  localparam int SRC_W = $clog2(NSRC);

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_IVAL = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;

  localparam int BIT_EN  = 0;
  localparam int BIT_RLD = 1;
  localparam int SRC_LO  = 2;
  localparam int EXP_LO  = 4;

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [SRC_W-1:0] src;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic              ctrl_wr,
  output logic              reload,
  output logic [CNT_W-1:0]  interval,
  output logic [DATA_W-1:0] rdata
);
  logic ival_wr;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign ival_wr = bus_wr && (bus_addr == OFS_IVAL);
  assign reload  = ctrl_wr && bus_wdata[BIT_RLD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      interval <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.en  <= bus_wdata[BIT_EN];
        ctrl.src <= bus_wdata[SRC_LO +: SRC_W];
        ctrl.exp <= bus_wdata[EXP_LO +: EXP_W];
      end
      if (ival_wr) interval <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: rdata = DATA_W'({ctrl.exp, ctrl.src, 1'b0, ctrl.en});
      OFS_IVAL: rdata = DATA_W'(interval);
      OFS_CNT:  rdata = DATA_W'(count);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
  import itmr_pkg::*;
#(
  parameter logic [NSRC-1:0] SRC_AVAIL = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  ctrl_t           ctrl,
  input  logic            ctrl_wr,
  output logic            step,
  output logic            src_bad,
  output logic            src_err
);
  localparam int PH_W = (1 << EXP_W) - 1;

  logic [NSRC-1:0] gated;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] limit;
  logic            tick;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    if (SRC_AVAIL[g]) begin : g_on
      assign gated[g] = src_tick[g];
    end else begin : g_off
      assign gated[g] = 1'b0;
    end
  end

  assign src_bad = !SRC_AVAIL[ctrl.src];
  assign tick    = gated[ctrl.src] && ctrl.en && !ctrl_wr;
  assign limit   = ~({PH_W{1'b1}} << ctrl.exp);
  assign step    = tick && (phase == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      src_err <= 1'b0;
    end else begin
      src_err <= src_err | src_bad;
      if (ctrl_wr || step) phase <= '0;
      else if (tick)       phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             step,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic last;

  assign last = (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (reload) begin
        count <= interval;
      end else if (step) begin
        if (last) begin
          count <= interval;
          irq   <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
  import itmr_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               CNT_W     = 32,
  parameter logic [NSRC-1:0]  SRC_AVAIL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_tick,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              src_err
);
  ctrl_t            ctrl_q;
  logic             ctrl_wr;
  logic             reload;
  logic             step;
  logic             src_bad;
  logic [CNT_W-1:0] interval_q;
  logic [CNT_W-1:0] count_q;

  itmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count(count_q), .ctrl(ctrl_q),
    .ctrl_wr(ctrl_wr), .reload(reload), .interval(interval_q),
    .rdata(bus_rdata)
  );

  itmr_prescaler #(.SRC_AVAIL(SRC_AVAIL)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ctrl(ctrl_q),
    .ctrl_wr(ctrl_wr), .step(step), .src_bad(src_bad), .src_err(src_err)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .reload(reload), .step(step),
    .interval(interval_q), .count(count_q), .irq(irq)
  );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ctrl_en,
  input logic              src_bad,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  interval,
  input logic              irq,
  input logic              src_err
);
  logic rld_wr;
  assign rld_wr = bus_wr && (bus_addr == 4'h0) && bus_wdata[1];

  assert_reload_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rld_wr |=> count == $past(interval));

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !rld_wr) |=> count == $past(count));

  assert_irq_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == $past(interval)) && $past(ctrl_en));

  assert_rld_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'h0) |-> !bus_rdata[1]);

  assert_bad_src_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_bad && !rld_wr) |=> count == $past(count));

  assert_bad_src_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_bad |=> src_err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |=> src_err);
endmodule

bind tick_interval_timer itmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_en(ctrl_q.en),
  .src_bad(src_bad), .count(count_q), .interval(interval_q),
  .irq(irq), .src_err(src_err)
);

// File: tb/tick_interval_timer_tb.sv
module tick_interval_timer_tb;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        src_tick = '0;
  logic              bus_wr = 1'b0;
  logic [3:0]        bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;
  logic              src_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ref_cyc = 0;
  int exp_q[$];

  tick_interval_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SRC_AVAIL(4'b1011)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .src_err(src_err)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // tick sources: 0 every cycle, 1 every second, 2 every cycle (absent), 3 every third
  always @(negedge clk) begin
    src_tick[0] = 1'b1;
    src_tick[1] = (cyc % 2 == 0);
    src_tick[2] = 1'b1;
    src_tick[3] = (cyc % 3 == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compare each interrupt gap against the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq) begin
      int gap;
      gap = cyc - ref_cyc;
      ref_cyc = cyc;
      if (exp_q.size() == 0) begin
        chk(0, "R6 unexpected irq", gap, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e >= 0) chk(gap == e, "R6 irq gap", gap, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    if (a == 4'h0) ref_cyc = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int cw(input int en, input int rld, input int src, input int ex);
    return (ex << 4) | (src << 2) | (rld << 1) | en;
  endfunction

  task automatic drain_and_stop();
    wait (exp_q.size() == 0);
    wr(4'h0, 0);
    idle(2);
  endtask

  always @(posedge clk) begin
    if (cyc > 60000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 60000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, v2;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(4'h0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(4'h4, v); chk(v == 0, "R1 interval", v, 0);
    rd(4'h8, v); chk(v == 0, "R1 count", v, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(src_err == 0, "R1 src_err", src_err, 0);

    // R9 interval write leaves count alone
    wr(4'h4, 5);
    rd(4'h4, v); chk(v == 5, "R2 interval readback", v, 5);
    rd(4'h8, v); chk(v == 0, "R9 count untouched", v, 0);

    // R5/R6 source 0, divide 1, interval 5
    exp_q.push_back(5); exp_q.push_back(5); exp_q.push_back(5);
    wr(4'h0, cw(1, 1, 0, 0));
    rd(4'h0, v); chk(v == 1, "R3 reload reads 0", v, 1);
    drain_and_stop();

    // R5 disabled holds; R2 count is read-only; R9 again
    rd(4'h8, v);
    idle(20);
    rd(4'h8, v2); chk(v2 == v, "R5 hold when off", v2, v);
    wr(4'h8, 77);
    rd(4'h8, v2); chk(v2 == v, "R2 count read-only", v2, v);
    wr(4'h4, 9);
    rd(4'h8, v2); chk(v2 == v, "R9 count after interval write", v2, v);
    rd(4'hC, v2); chk(v2 == 0, "R2 unmapped offset", v2, 0);

    // R4 reload without enable
    wr(4'h0, cw(0, 1, 0, 0));
    rd(4'h8, v); chk(v == 9, "R4 reload while off", v, 9);
    rd(4'h0, v); chk(v == 0, "R3 ctrl after reload-only", v, 0);

    // R5 divide by 4, interval 3
    wr(4'h4, 3);
    exp_q.push_back(12); exp_q.push_back(12);
    wr(4'h0, cw(1, 1, 0, 2));
    rd(4'h0, v); chk(v == 'h21, "R3 field readback", v, 'h21);
    drain_and_stop();

    // R5 maximum divide 128, interval 1
    wr(4'h4, 1);
    exp_q.push_back(128); exp_q.push_back(128);
    wr(4'h0, cw(1, 1, 0, 7));
    drain_and_stop();

    // R5 source 1 (every other cycle), divide 2, interval 4
    wr(4'h4, 4);
    exp_q.push_back(-1); exp_q.push_back(16); exp_q.push_back(16);
    wr(4'h0, cw(1, 1, 1, 1));
    drain_and_stop();

    // R5 source 3 (every third cycle), divide 1, interval 2
    wr(4'h4, 2);
    exp_q.push_back(-1); exp_q.push_back(6);
    wr(4'h0, cw(1, 1, 3, 0));
    drain_and_stop();

    // R7 phase restart: rewrite mid-period, full period follows
    wr(4'h0, cw(1, 1, 0, 3));
    idle(5);
    exp_q.push_back(16);
    wr(4'h0, cw(1, 1, 0, 3));
    drain_and_stop();

    // R8 absent source 2
    chk(src_err == 0, "R8 no error yet", src_err, 0);
    wr(4'h4, 3);
    wr(4'h0, cw(1, 1, 2, 0));
    idle(2);
    chk(src_err == 1, "R8 error set", src_err, 1);
    rd(4'h8, v); chk(v == 3, "R8 count after reload", v, 3);
    idle(30);
    rd(4'h8, v); chk(v == 3, "R8 count frozen", v, 3);
    exp_q.push_back(3);
    wr(4'h0, cw(1, 1, 0, 0));
    drain_and_stop();
    chk(src_err == 1, "R8 error sticky", src_err, 1);

    idle(5);
    chk(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule